// File: doc/BRIEF.md
# Sector Single-Bit Correcting Parity Code

This block builds a line/column parity code over one sector of data while the bytes stream past. Every data bit has a 12-bit address: the byte index within the sector in the upper 9 bits and the bit position within the byte in the lower 3. For each address bit the block keeps two parities over all set data bits. One covers the bits whose address bit is 1 and the other covers the bits whose address bit is 0. Both 12-bit groups are packed into a 24-bit word, which is then inverted, so a fully erased sector (all bytes 0xFF) yields 0xFFFFFF.

On a write the caller takes the computed code and stores it beside the data. On a read the caller streams the data again and presents the stored code with a compare strobe. The block then reports one of four results: the data is clean, a single data bit is wrong (the block gives its byte index and bit index), a single bit of the stored code is wrong and the data needs no change, or the data cannot be corrected. Taking the code, or comparing, restarts accumulation for the next sector. The block neither buffers data nor applies the correction.

Top module: `sector_hamming_ecc`

## Requirements
- R1: After reset `code_out` is 0xFFFFFF, `res_valid` is 0, and the error location fields are 0.
- R2: `code_out` bit 12+k is the inverted XOR over set data bits whose address bit k is 1. Bit k is the inverted XOR over set data bits whose address bit k is 0. Address bits 2:0 are the bit position within the byte and bits 11:3 are the byte index. For example, byte 0x01 alone gives 0xFFF000, and bytes 0x00,0x80 give 0xFF000F.
- R3: A sector of 512 bytes of 0xFF produces `code_out` = 0xFFFFFF.
- R4: A byte with `in_first` high is counted as byte 0 of a new sector, and all earlier accumulation is discarded.
- R5: A cycle with `code_take` or `cmp_req` high restarts accumulation. With no byte in that cycle, `code_out` is 0xFFFFFF on the next cycle. A byte in that same cycle counts as byte 0 of the new sector.
- R6: `res_valid` is high for exactly the one cycle that follows each cycle with `cmp_req` high, and is low at all other times.
- R7: When the stored code equals the computed code, `res_kind` is 0 (clean).
- R8: When the upper 12 bits of the difference (computed XOR stored) are the exact complement of the lower 12 bits, `res_kind` is 1 (corrected), `fix_byte` = difference bits 23:15 and `fix_bit` = difference bits 14:12.
- R9: When exactly one bit of the difference is set, `res_kind` is 2 (code fault).
- R10: Any other nonzero difference gives `res_kind` 3 (uncorrectable).
- R11: `fix_byte` and `fix_bit` are 0 whenever the result is not 1.
- R12: `code_out` includes a byte on the cycle after the byte is accepted and is unchanged in cycles with no byte and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A data byte is present |
| in_first | input | 1 | This byte opens a new sector |
| in_byte | input | 8 | Data byte |
| code_take | input | 1 | Code consumed; restart accumulation |
| cmp_req | input | 1 | Compare `ref_code` with the computed code and restart |
| ref_code | input | 24 | Stored code, sampled with `cmp_req` |
| code_out | output | 24 | Computed, inverted code (LSB byte is emitted first) |
| res_valid | output | 1 | Result fields are valid this cycle |
| res_kind | output | 2 | 0 clean, 1 corrected, 2 code fault, 3 uncorrectable |
| fix_byte | output | 9 | Byte index of the faulty data bit |
| fix_bit | output | 3 | Bit index of the faulty data bit |

## Verification
A byte driven at one falling edge is in `code_out` after the next rising edge. A compare strobe gives its result one rising edge later. The bench drives all inputs at falling edges and reads `code_out` at the first falling edge after the last byte. Each compare pushes its expected kind and location into a queue. A monitor pops one entry on each falling edge where `res_valid` is high, so any early, late, extra or missing result appears as a mismatch or as a leftover entry.

// File: rtl/sector_ecc_pkg.sv
package sector_ecc_pkg;

   typedef enum logic [1:0] {
      KIND_CLEAN = 2'd0,
      KIND_FIXED = 2'd1,
      KIND_CODE  = 2'd2,
      KIND_BAD   = 2'd3
   } res_kind_t;

   // Bits of a byte whose in-byte position has address bit k set.
   function automatic logic [7:0] lane_mask(input int k);
      logic [7:0] m;
      for (int i = 0; i < 8; i++) m[i] = ((i >> k) & 1) == 1;
      return m;
   endfunction

endpackage

// File: rtl/sector_ecc_accum.sv
module sector_ecc_accum #(
   parameter int SECTOR_BYTES = 512,
   localparam int IDX_W = $clog2(SECTOR_BYTES),
   localparam int HALF_W = IDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic [7:0]        in_byte,
   input  logic              restart,
   output logic [HALF_W-1:0] odd_par,
   output logic [HALF_W-1:0] even_par
);
   import sector_ecc_pkg::*;

   logic [IDX_W-1:0]  byte_cnt;
   logic [IDX_W-1:0]  base_idx;
   logic [HALF_W-1:0] add_odd, add_even;
   logic              byte_par;
   logic              fresh;

   assign fresh    = in_first | restart;
   assign base_idx = fresh ? '0 : byte_cnt;
   assign byte_par = ^in_byte;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_lane
         assign add_odd[k]  = ^(in_byte & lane_mask(k));
         assign add_even[k] = ^(in_byte & ~lane_mask(k));
      end
      for (genvar j = 0; j < IDX_W; j++) begin : g_row
         assign add_odd[3+j]  = byte_par &  base_idx[j];
         assign add_even[3+j] = byte_par & ~base_idx[j];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         odd_par  <= '0;
         even_par <= '0;
      end else if (in_valid) begin
         byte_cnt <= base_idx + 1'b1;
         odd_par  <= (fresh ? '0 : odd_par)  ^ add_odd;
         even_par <= (fresh ? '0 : even_par) ^ add_even;
      end else if (restart) begin
         byte_cnt <= '0;
         odd_par  <= '0;
         even_par <= '0;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !restart) |=> ($stable(odd_par) && $stable(even_par))); // R12

endmodule

// File: rtl/sector_ecc_classify.sv
module sector_ecc_classify #(
   parameter int SECTOR_BYTES = 512,
   localparam int IDX_W = $clog2(SECTOR_BYTES),
   localparam int HALF_W = IDX_W + 3,
   localparam int CODE_W = 2 * HALF_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmp_req,
   input  logic [CODE_W-1:0]             calc_code,
   input  logic [CODE_W-1:0]             ref_code,
   output logic                          res_valid,
   output sector_ecc_pkg::res_kind_t     res_kind,
   output logic [IDX_W-1:0]              fix_byte,
   output logic [2:0]                    fix_bit
);
   import sector_ecc_pkg::*;

   logic [CODE_W-1:0] diff;
   logic [HALF_W-1:0] hi, lo;
   logic              halves_cpl, in_range, one_hot;
   res_kind_t         kind_d;

   assign diff       = calc_code ^ ref_code;
   assign hi         = diff[CODE_W-1:HALF_W];
   assign lo         = diff[HALF_W-1:0];
   assign halves_cpl = (hi ^ lo) == {HALF_W{1'b1}};
   assign one_hot    = $onehot(diff);

   generate
      if (SECTOR_BYTES == (1 << IDX_W)) begin : g_pow2
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = 32'(hi[HALF_W-1:3]) < SECTOR_BYTES;
      end
   endgenerate

   always_comb begin
      if (diff == '0)                  kind_d = KIND_CLEAN;
      else if (halves_cpl && in_range) kind_d = KIND_FIXED;
      else if (halves_cpl)             kind_d = KIND_BAD;
      else if (one_hot)                kind_d = KIND_CODE;
      else                             kind_d = KIND_BAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_kind  <= KIND_CLEAN;
         fix_byte  <= '0;
         fix_bit   <= '0;
      end else begin
         res_valid <= cmp_req;
         if (cmp_req) begin
            res_kind <= kind_d;
            fix_byte <= (kind_d == KIND_FIXED) ? hi[HALF_W-1:3] : '0;
            fix_bit  <= (kind_d == KIND_FIXED) ? hi[2:0] : '0;
         end
      end
   end

   AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req |=> res_valid); // R6
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_req |=> !res_valid); // R6
   AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_req && calc_code == ref_code) |=> res_kind == KIND_CLEAN); // R7
   AST_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind != KIND_FIXED) |-> (fix_byte == '0 && fix_bit == '0)); // R11

endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc #(
   parameter int SECTOR_BYTES = 512,
   localparam int IDX_W = $clog2(SECTOR_BYTES),
   localparam int HALF_W = IDX_W + 3,
   localparam int CODE_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic [7:0]        in_byte,
   input  logic              code_take,
   input  logic              cmp_req,
   input  logic [CODE_W-1:0] ref_code,
   output logic [CODE_W-1:0] code_out,
   output logic              res_valid,
   output logic [1:0]        res_kind,
   output logic [IDX_W-1:0]  fix_byte,
   output logic [2:0]        fix_bit
);
   import sector_ecc_pkg::*;

   generate
      if (SECTOR_BYTES < 2) begin : g_bad_size
         $error("SECTOR_BYTES must be at least 2");
      end
   endgenerate

   logic [HALF_W-1:0] odd_par, even_par;
   logic              restart;
   res_kind_t         kind;

   assign restart  = code_take | cmp_req;
   assign code_out = ~{odd_par, even_par};
   assign res_kind = kind;

   sector_ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_byte(in_byte), .restart(restart), .odd_par(odd_par), .even_par(even_par)
   );

   sector_ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_class (
      .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .calc_code(code_out),
      .ref_code(ref_code), .res_valid(res_valid), .res_kind(kind),
      .fix_byte(fix_byte), .fix_bit(fix_bit)
   );

   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !in_valid) |=> code_out == {CODE_W{1'b1}}); // R5

endmodule

// File: tb/tb_sector_hamming_ecc.sv
module tb_sector_hamming_ecc;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_first = 1'b0, code_take = 1'b0, cmp_req = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [23:0] ref_code = '0;
   logic [23:0] code_out;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [8:0]  fix_byte;
   logic [2:0]  fix_bit;

   int total = 0, bad = 0, cyc = 0;
   logic [7:0] mem [0:511];
   logic [13:0] expq [$];   // {kind, byte, bit}

   sector_hamming_ecc dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_byte(in_byte), .code_take(code_take), .cmp_req(cmp_req),
      .ref_code(ref_code), .code_out(code_out), .res_valid(res_valid),
      .res_kind(res_kind), .fix_byte(fix_byte), .fix_bit(fix_bit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input int n);
      logic [11:0] p = '0, e = '0;
      for (int i = 0; i < n; i++)
         for (int t = 0; t < 8; t++)
            if (mem[i][t]) begin
               p ^= {i[8:0], t[2:0]};
               e ^= ~{i[8:0], t[2:0]};
            end
      return ~{p, e};
   endfunction

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + seed * 11) ^ (i >> 3) ^ (seed << 4));
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1; in_first = (i == 0); in_byte = mem[i];
         @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0;
   endtask

   task automatic compare(input logic [23:0] stored, input logic [1:0] k, input logic [8:0] b, input logic [2:0] t);
      cmp_req = 1'b1; ref_code = stored;
      expq.push_back({k, b, t});
      @(negedge clk);
      cmp_req = 1'b0;
   endtask

   // Monitor: one expected entry per valid result.
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (expq.size() == 0) chk(1'b0, "R6 unexpected result", 32'(res_kind), 32'hx);
         else begin
            logic [13:0] e;
            e = expq.pop_front();
            chk(res_kind == e[13:12], "R7-R10 kind", 32'(res_kind), 32'(e[13:12]));
            chk({fix_byte, fix_bit} == e[11:0], "R8/R11 location",
                32'({fix_byte, fix_bit}), 32'(e[11:0]));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] good;
      repeat (3) @(negedge clk);
      // R1
      chk(code_out == 24'hFFFFFF, "R1 reset code", code_out, 24'hFFFFFF);
      chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
      chk({fix_byte, fix_bit} == 0, "R1 reset location", {fix_byte, fix_bit}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 literal patterns
      mem[0] = 8'h01; send(1);
      chk(code_out == 24'hFFF000, "R2 single byte 01", code_out, 24'hFFF000);
      code_take = 1'b1; @(negedge clk); code_take = 1'b0;
      chk(code_out == 24'hFFFFFF, "R5 take empties", code_out, 24'hFFFFFF);
      mem[0] = 8'h00; mem[1] = 8'h80; send(2);
      chk(code_out == 24'hFF000F, "R2 bytes 00,80", code_out, 24'hFF000F);

      // R3 erased sector, then R7 clean compare
      for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
      send(512);
      chk(code_out == 24'hFFFFFF, "R3 erased sector", code_out, 24'hFFFFFF);
      compare(24'hFFFFFF, 2'd0, 9'd0, 3'd0);
      chk(code_out == 24'hFFFFFF, "R5 compare restarts", code_out, 24'hFFFFFF);

      // R2 full sector model, R7
      fill(512, 3); send(512);
      good = model(512);
      chk(code_out == good, "R2 full sector", code_out, good);
      compare(good, 2'd0, 9'd0, 3'd0);

      // R8 corrected data bit at byte 40 bit 5
      fill(64, 5); good = model(64);
      mem[40] ^= 8'h20;
      send(64);
      compare(good, 2'd1, 9'd40, 3'd5);
      // R8 at byte 0 bit 0
      fill(64, 6); good = model(64);
      mem[0] ^= 8'h01;
      send(64);
      compare(good, 2'd1, 9'd0, 3'd0);
      // R8 last byte of full sector, bit 7
      fill(512, 8); good = model(512);
      mem[511] ^= 8'h80;
      send(512);
      compare(good, 2'd1, 9'd511, 3'd7);

      // R9 code faults, R10 uncorrectable
      fill(64, 7); good = model(64);
      send(64); compare(good ^ 24'h000100, 2'd2, 9'd0, 3'd0);
      send(64); compare(good ^ 24'h800000, 2'd2, 9'd0, 3'd0);
      send(64); compare(good ^ 24'h000003, 2'd3, 9'd0, 3'd0);
      send(64); compare(good ^ 24'hFFFFFF, 2'd3, 9'd0, 3'd0);
      // R10 two data bits flipped
      good = model(64); mem[3] ^= 8'h11; send(64);
      compare(good, 2'd3, 9'd0, 3'd0);

      // R4 new sector discards partial one
      fill(10, 9); send(10);
      fill(20, 10); good = model(20); send(20);
      chk(code_out == good, "R4 sector start", code_out, good);

      // R5 byte on a restart cycle counts as byte 0
      mem[0] = 8'h01;
      code_take = 1'b1; in_valid = 1'b1; in_byte = 8'h01;
      @(negedge clk);
      code_take = 1'b0; in_valid = 1'b0;
      chk(code_out == 24'hFFF000, "R5 byte with take", code_out, 24'hFFF000);
      // R12 hold while idle
      repeat (3) @(negedge clk);
      chk(code_out == 24'hFFF000, "R12 idle hold", code_out, 24'hFFF000);

      // R6 back-to-back compares
      compare(24'hFFF000, 2'd0, 9'd0, 3'd0);
      compare(24'hFFFFFF, 2'd0, 9'd0, 3'd0);
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R6 missing results", expq.size(), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule